// File: doc/BRIEF.md
# Frame Memory Rectangle Transfer Engine

This block plans the movement of pixels between a stream of 32-bit words and a frame memory of 1024 columns by 512 rows, each location holding one 16-bit pixel. A start command carries a position word, a size word and a direction flag, and it defines a rectangle in the frame memory. Each word of the stream holds two pixels. The words then arrive in bursts, and each burst is announced with its length in words. A burst can end anywhere in the rectangle, including in the middle of a row. The block keeps the current row, the number of rows left and the column offset inside a partly done row. The next burst therefore continues exactly where the last one stopped.

For each burst the block issues a sequence of line segments to the frame memory, one per clock. Each segment gives a column, a row, a length in pixels and the index of its first pixel inside the burst, so that an outside data path can read or write that part of the burst. When the burst has been planned, the block pulses a completion strobe. The strobe comes with the number of words actually used, which is less than the burst length once the rectangle has run out of rows. Starting a new rectangle while rows of the old one remain is allowed, and it raises a one-cycle warning.

Top module: `vrtx_engine`

## Requirements
- R1: On start, the column origin is the position word's bits 9:0 and the starting row is its bits 24:16. The row width in pixels is the size word's bits 15:0, and the row count is its bits 31:16. The column offset is cleared.
- R2: A burst of N words supplies 2N pixels. Within a burst the segments are issued in order, and each segment's `line_src` equals the number of pixels of that burst taken by the segments before it, starting at 0.
- R3: With no column offset pending, while rows remain and at least one full row of pixels is left, a segment is issued at the column origin on the current row with length equal to the width. The row then advances by one and the row count drops by one.
- R4: When fewer than a full row of pixels are left, with rows remaining and no offset pending, one segment is issued at the column origin with length equal to the leftover. That length becomes the pending column offset.
- R5: With an offset pending, the first segment of the next burst starts at column (origin + offset) mod 1024. Its length is the smaller of (width − offset) and the pixels available. If this completes the row, the offset clears, the row advances and the row count drops; otherwise the offset grows by the length.
- R6: The row number wraps from 511 to 0.
- R7: The completion strobe `done` reports the burst length minus ceil(unused pixels / 2) on `done_words`. Unused pixels are those left after the rows run out.
- R8: `busy` is 1 exactly while the remaining row count is nonzero. It is 0 after reset.
- R9: A start accepted while the row count is nonzero makes `restart_warn` 1 for the single cycle after the accepting edge. Otherwise `restart_warn` stays 0.
- R10: Every segment's `line_rd` equals the direction flag of the last accepted start (1 = frame memory to stream, 0 = stream to frame memory).
- R11: If the width or the row count is 0, a burst issues no segments and reports 0 words used.
- R12: `idle` is 1 after reset. It falls on the edge that accepts a burst and stays 0 until that burst's segments are planned. Start and burst requests are taken only while `idle` is 1, and start wins if both are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_vld | input | 1 | Start a new rectangle |
| start_pos | input | 32 | Position word: column in 9:0, row in 24:16 |
| start_size | input | 32 | Size word: width in 15:0, rows in 31:16 |
| start_rd | input | 1 | Direction, 1 = read from frame memory |
| burst_vld | input | 1 | Announce a burst |
| burst_words | input | CNTW | Burst length in 32-bit words |
| idle | output | 1 | Ready to take a start or a burst |
| busy | output | 1 | Rows of the rectangle remain |
| restart_warn | output | 1 | Start accepted while rows remained |
| line_vld | output | 1 | Segment valid |
| line_rd | output | 1 | Segment direction |
| line_x | output | XW | Segment start column |
| line_y | output | YW | Segment row |
| line_len | output | DIMW | Segment length in pixels |
| line_src | output | CNTW+1 | Index of the segment's first pixel within the burst |
| done | output | 1 | Burst fully planned |
| done_words | output | CNTW | Words of the burst that were used |

## Verification
The hardest situation to reach is a row that is split over three or more bursts. In that case the pending offset has to grow twice before the row completes, and the completing burst must then carry on into the next row's leftover. The stimulus reaches it with a wide row fed by one- and two-word bursts, followed by a burst that spans the end of the row. Other sequences place the end of a burst exactly on a row boundary and run the row number across 511, and one feeds an odd pixel leftover into a rectangle that then runs out, so that the rounded word count is exercised.

// File: rtl/vrtx_pkg.sv
package vrtx_pkg;

   // Kind of segment chosen for the current planning step
   typedef enum logic [1:0] {
      SEG_NONE = 2'd0,
      SEG_PART = 2'd1,
      SEG_ROW  = 2'd2,
      SEG_TAIL = 2'd3
   } seg_kind_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } ctl_st_e;

endpackage

// File: rtl/vrtx_seg_plan.sv
module vrtx_seg_plan
   import vrtx_pkg::*;
#(
   parameter int XW   = 10,
   parameter int YW   = 9,
   parameter int DIMW = 16,
   parameter int PCW  = 17
) (
   input  logic [XW-1:0]   cur_x,
   input  logic [YW-1:0]   cur_y,
   input  logic [DIMW-1:0] cur_w,
   input  logic [DIMW-1:0] cur_h,
   input  logic [DIMW-1:0] cur_off,
   input  logic [PCW-1:0]  pix_left,
   output seg_kind_e       kind,
   output logic [DIMW-1:0] seg_len,
   output logic [XW-1:0]   seg_x,
   output logic [YW-1:0]   seg_y
);

   localparam int LW = (DIMW > PCW) ? DIMW : PCW;

   logic [LW:0] w_e, off_e, p_e, room, part_len;

   assign w_e      = (LW+1)'(cur_w);
   assign off_e    = (LW+1)'(cur_off);
   assign p_e      = (LW+1)'(pix_left);
   assign room     = w_e - off_e;
   assign part_len = (p_e < room) ? p_e : room;

   always_comb begin
      kind    = SEG_NONE;
      seg_len = '0;
      seg_x   = cur_x;
      seg_y   = cur_y;
      if (cur_h != '0 && cur_w != '0 && pix_left != '0) begin
         if (cur_off != '0) begin
            kind    = SEG_PART;
            seg_len = part_len[DIMW-1:0];
            seg_x   = cur_x + cur_off[XW-1:0];
         end else if (p_e >= w_e) begin
            kind    = SEG_ROW;
            seg_len = cur_w;
         end else begin
            kind    = SEG_TAIL;
            seg_len = p_e[DIMW-1:0];
         end
      end
   end

endmodule

// File: rtl/vrtx_cursor.sv
module vrtx_cursor
   import vrtx_pkg::*;
#(
   parameter int XW   = 10,
   parameter int YW   = 9,
   parameter int DIMW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [XW-1:0]   ld_x,
   input  logic [YW-1:0]   ld_y,
   input  logic [DIMW-1:0] ld_w,
   input  logic [DIMW-1:0] ld_h,
   input  logic            step,
   input  seg_kind_e       step_kind,
   input  logic [DIMW-1:0] step_len,
   output logic [XW-1:0]   cur_x,
   output logic [YW-1:0]   cur_y,
   output logic [DIMW-1:0] cur_w,
   output logic [DIMW-1:0] cur_h,
   output logic [DIMW-1:0] cur_off
);

   logic [DIMW:0] off_sum;
   assign off_sum = {1'b0, cur_off} + {1'b0, step_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_x   <= '0;
         cur_y   <= '0;
         cur_w   <= '0;
         cur_h   <= '0;
         cur_off <= '0;
      end else if (load) begin
         cur_x   <= ld_x;
         cur_y   <= ld_y;
         cur_w   <= ld_w;
         cur_h   <= ld_h;
         cur_off <= '0;
      end else if (step) begin
         unique case (step_kind)
            SEG_PART: begin
               if (off_sum < {1'b0, cur_w}) begin
                  cur_off <= off_sum[DIMW-1:0];
               end else begin
                  cur_off <= '0;
                  cur_y   <= cur_y + 1'b1;
                  cur_h   <= cur_h - 1'b1;
               end
            end
            SEG_ROW: begin
               cur_y <= cur_y + 1'b1;
               cur_h <= cur_h - 1'b1;
            end
            SEG_TAIL: cur_off <= step_len;
            default: ;
         endcase
      end
   end

   // R5
   off_lt_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_off == '0) || (cur_off < cur_w));

   // R3
   rows_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && step_kind == SEG_ROW) |=> (cur_h == $past(cur_h) - 1'b1));

   // R6
   row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && step_kind == SEG_ROW && cur_y == '1) |=> (cur_y == '0));

endmodule

// File: rtl/vrtx_burst_ctl.sv
module vrtx_burst_ctl
   import vrtx_pkg::*;
#(
   parameter int CNTW = 16,
   parameter int PCW  = 17,
   parameter int DIMW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_vld,
   input  logic            burst_vld,
   input  logic [CNTW-1:0] burst_words,
   input  seg_kind_e       kind,
   input  logic [DIMW-1:0] seg_len,
   input  logic [DIMW-1:0] rows_left,
   output logic            idle,
   output logic            load,
   output logic            step,
   output logic [PCW-1:0]  pix_left,
   output logic [PCW-1:0]  seg_src,
   output logic            fin,
   output logic [CNTW-1:0] fin_words,
   output logic            warn
);

   ctl_st_e         st;
   logic            take;
   logic [CNTW-1:0] words_in;
   logic [PCW:0]    unused_half;

   assign idle = (st == ST_IDLE);
   assign load = idle && start_vld;
   assign take = idle && !start_vld && burst_vld;
   assign step = (st == ST_RUN) && (kind != SEG_NONE);
   assign fin  = (st == ST_RUN) && (kind == SEG_NONE);

   assign unused_half = ({1'b0, pix_left} + 1'b1) >> 1;
   assign fin_words   = words_in - unused_half[CNTW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         pix_left <= '0;
         seg_src  <= '0;
         words_in <= '0;
         warn     <= 1'b0;
      end else begin
         warn <= load && (rows_left != '0);
         if (take) begin
            st       <= ST_RUN;
            pix_left <= {burst_words, 1'b0};
            seg_src  <= '0;
            words_in <= burst_words;
         end else if (step) begin
            pix_left <= pix_left - PCW'(seg_len);
            seg_src  <= seg_src + PCW'(seg_len);
         end else if (fin) begin
            st <= ST_IDLE;
         end
      end
   end

   // R2
   pix_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (pix_left == $past(pix_left) - PCW'($past(seg_len))));

   // R12
   fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> idle);

   // R12
   take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !idle);

endmodule

// File: rtl/vrtx_out_stage.sv
module vrtx_out_stage #(
   parameter int XW      = 10,
   parameter int YW      = 9,
   parameter int DIMW    = 16,
   parameter int PCW     = 17,
   parameter int CNTW    = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic            in_rd,
   input  logic [XW-1:0]   in_x,
   input  logic [YW-1:0]   in_y,
   input  logic [DIMW-1:0] in_len,
   input  logic [PCW-1:0]  in_src,
   input  logic            in_fin,
   input  logic [CNTW-1:0] in_fin_words,
   output logic            out_vld,
   output logic            out_rd,
   output logic [XW-1:0]   out_x,
   output logic [YW-1:0]   out_y,
   output logic [DIMW-1:0] out_len,
   output logic [PCW-1:0]  out_src,
   output logic            out_fin,
   output logic [CNTW-1:0] out_fin_words
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_vld       <= 1'b0;
               out_rd        <= 1'b0;
               out_x         <= '0;
               out_y         <= '0;
               out_len       <= '0;
               out_src       <= '0;
               out_fin       <= 1'b0;
               out_fin_words <= '0;
            end else begin
               out_vld       <= in_vld;
               out_rd        <= in_rd;
               out_x         <= in_x;
               out_y         <= in_y;
               out_len       <= in_len;
               out_src       <= in_src;
               out_fin       <= in_fin;
               out_fin_words <= in_fin_words;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk    = clk ^ rst_n;
         assign out_vld       = in_vld;
         assign out_rd        = in_rd;
         assign out_x         = in_x;
         assign out_y         = in_y;
         assign out_len       = in_len;
         assign out_src       = in_src;
         assign out_fin       = in_fin;
         assign out_fin_words = in_fin_words;
      end
   endgenerate

endmodule

// File: rtl/vrtx_engine.sv
module vrtx_engine
   import vrtx_pkg::*;
#(
   parameter int XW      = 10,
   parameter int YW      = 9,
   parameter int DIMW    = 16,
   parameter int CNTW    = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_vld,
   input  logic [31:0]       start_pos,
   input  logic [31:0]       start_size,
   input  logic              start_rd,
   input  logic              burst_vld,
   input  logic [CNTW-1:0]   burst_words,
   output logic              idle,
   output logic              busy,
   output logic              restart_warn,
   output logic              line_vld,
   output logic              line_rd,
   output logic [XW-1:0]     line_x,
   output logic [YW-1:0]     line_y,
   output logic [DIMW-1:0]   line_len,
   output logic [CNTW:0]     line_src,
   output logic              done,
   output logic [CNTW-1:0]   done_words
);

   localparam int PCW   = CNTW + 1;
   localparam int YLSB  = 16;

   generate
      if (XW < 1 || XW > 16) begin : g_bad_xw
         $error("vrtx_engine: XW must lie in 1..16");
      end
      if (YW < 1 || YLSB + YW > 32) begin : g_bad_yw
         $error("vrtx_engine: YW must fit above bit 16 of the position word");
      end
      if (DIMW < 1 || 2 * DIMW > 32) begin : g_bad_dimw
         $error("vrtx_engine: two DIMW fields must fit in the size word");
      end
      if (CNTW < 1 || CNTW > 30) begin : g_bad_cntw
         $error("vrtx_engine: CNTW must lie in 1..30");
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{start_pos, start_size};

   seg_kind_e       kind;
   logic [DIMW-1:0] seg_len;
   logic [XW-1:0]   seg_x, cur_x;
   logic [YW-1:0]   seg_y, cur_y;
   logic [DIMW-1:0] cur_w, cur_h, cur_off;
   logic [PCW-1:0]  pix_left, seg_src;
   logic            load, step, fin;
   logic [CNTW-1:0] fin_words;
   logic            dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dir_q <= 1'b0;
      else if (load) dir_q <= start_rd;
   end

   assign busy = (cur_h != '0);

   vrtx_burst_ctl #(.CNTW(CNTW), .PCW(PCW), .DIMW(DIMW)) ctl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_vld   (start_vld),
      .burst_vld   (burst_vld),
      .burst_words (burst_words),
      .kind        (kind),
      .seg_len     (seg_len),
      .rows_left   (cur_h),
      .idle        (idle),
      .load        (load),
      .step        (step),
      .pix_left    (pix_left),
      .seg_src     (seg_src),
      .fin         (fin),
      .fin_words   (fin_words),
      .warn        (restart_warn)
   );

   vrtx_cursor #(.XW(XW), .YW(YW), .DIMW(DIMW)) cur_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .ld_x      (start_pos[XW-1:0]),
      .ld_y      (start_pos[YLSB +: YW]),
      .ld_w      (start_size[DIMW-1:0]),
      .ld_h      (start_size[DIMW +: DIMW]),
      .step      (step),
      .step_kind (kind),
      .step_len  (seg_len),
      .cur_x     (cur_x),
      .cur_y     (cur_y),
      .cur_w     (cur_w),
      .cur_h     (cur_h),
      .cur_off   (cur_off)
   );

   vrtx_seg_plan #(.XW(XW), .YW(YW), .DIMW(DIMW), .PCW(PCW)) plan_i (
      .cur_x    (cur_x),
      .cur_y    (cur_y),
      .cur_w    (cur_w),
      .cur_h    (cur_h),
      .cur_off  (cur_off),
      .pix_left (pix_left),
      .kind     (kind),
      .seg_len  (seg_len),
      .seg_x    (seg_x),
      .seg_y    (seg_y)
   );

   vrtx_out_stage #(
      .XW(XW), .YW(YW), .DIMW(DIMW), .PCW(PCW), .CNTW(CNTW), .REG_OUT(REG_OUT)
   ) out_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_vld        (step),
      .in_rd         (dir_q),
      .in_x          (seg_x),
      .in_y          (seg_y),
      .in_len        (seg_len),
      .in_src        (seg_src),
      .in_fin        (fin),
      .in_fin_words  (fin_words),
      .out_vld       (line_vld),
      .out_rd        (line_rd),
      .out_x         (line_x),
      .out_y         (line_y),
      .out_len       (line_len),
      .out_src       (line_src),
      .out_fin       (done),
      .out_fin_words (done_words)
   );

   // R3
   seg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_vld |-> (line_len != '0));

   // R7
   seg_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({line_vld, done}));

   // R10
   dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_vld && $past(line_vld)) |-> $stable(line_rd));

   // R11
   empty_rect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_w == '0 || cur_h == '0) |-> !step);

endmodule

// File: tb/vrtx_engine_tb.sv
module vrtx_engine_tb_top;

   localparam int CLK_P = 10;
   localparam int CNTW  = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_vld = 1'b0;
   logic [31:0]     start_pos = '0;
   logic [31:0]     start_size = '0;
   logic            start_rd = 1'b0;
   logic            burst_vld = 1'b0;
   logic [CNTW-1:0] burst_words = '0;
   logic            idle, busy, restart_warn, line_vld, line_rd, done;
   logic [9:0]      line_x;
   logic [8:0]      line_y;
   logic [15:0]     line_len;
   logic [CNTW:0]   line_src;
   logic [CNTW-1:0] done_words;

   always #(CLK_P/2) clk = ~clk;

   vrtx_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_pos(start_pos),
      .start_size(start_size), .start_rd(start_rd), .burst_vld(burst_vld),
      .burst_words(burst_words), .idle(idle), .busy(busy),
      .restart_warn(restart_warn), .line_vld(line_vld), .line_rd(line_rd),
      .line_x(line_x), .line_y(line_y), .line_len(line_len),
      .line_src(line_src), .done(done), .done_words(done_words)
   );

   typedef struct {
      int    x;
      int    y;
      int    len;
      int    src;
      string tag;
   } seg_t;

   seg_t  exp_q[$];
   int    cons_q[$];
   string cons_tag_q[$];
   int    n_chk = 0;
   int    n_fail = 0;

   // reference state, built from the requirements
   int m_x = 0, m_y = 0, m_w = 0, m_h = 0, m_off = 0, m_rd = 0;
   bit m_first = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void push_seg(int x, int y, int len, int src, string tag);
      seg_t s;
      s.x = x; s.y = y; s.len = len; s.src = src;
      s.tag = m_first ? "R1" : tag;
      m_first = 1'b0;
      exp_q.push_back(s);
   endfunction

   // monitor: compares produced segments and completions against the queues
   seg_t e;
   int   c;
   string ct;
   always @(negedge clk) begin
      if (rst_n) begin
         if (line_vld) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected segment", longint'(line_len), 0);
            end else begin
               e = exp_q.pop_front();
               chk(line_x == 10'(e.x) && line_y == 9'(e.y) && line_len == 16'(e.len), e.tag,
                   {line_x, line_y, line_len}, {10'(e.x), 9'(e.y), 16'(e.len)});
               chk(line_src == 17'(e.src), "R2", longint'(line_src), longint'(e.src));
               chk(line_rd == m_rd[0], "R10", longint'(line_rd), longint'(m_rd));
            end
         end
         if (done) begin
            if (cons_q.size() == 0) begin
               chk(1'b0, "R7 unexpected done", longint'(done_words), 0);
            end else begin
               c  = cons_q.pop_front();
               ct = cons_tag_q.pop_front();
               chk(done_words == 16'(c), ct, longint'(done_words), longint'(c));
            end
         end
      end
   end

   task automatic do_start(input int x, input int y, input int w, input int h, input bit rd);
      bit exp_warn;
      exp_warn  = (m_h != 0);
      m_x = x % 1024; m_y = y % 512; m_w = w; m_h = h; m_off = 0; m_rd = rd;
      m_first   = 1'b1;
      start_pos  = (32'(y) << 16) | 32'(x);
      start_size = (32'(h) << 16) | 32'(w);
      start_rd   = rd;
      start_vld  = 1'b1;
      @(negedge clk);
      start_vld  = 1'b0;
      // R9 warning pulse in the cycle after the accepting edge
      chk(restart_warn == exp_warn, "R9", longint'(restart_warn), longint'(exp_warn));
      // R8 busy follows the loaded row count
      chk(busy == (h != 0), "R8", longint'(busy), longint'(h != 0));
      @(negedge clk);
      chk(restart_warn == 1'b0, "R9 pulse length", longint'(restart_warn), 0);
   endtask

   task automatic do_burst(input int words);
      int p, src, l;
      bit empty;
      p = 2 * words;
      src = 0;
      empty = (m_w == 0 || m_h == 0);
      while (m_h != 0 && m_w != 0 && p != 0) begin
         if (m_off != 0) begin
            l = (m_w - m_off < p) ? (m_w - m_off) : p;
            push_seg((m_x + m_off) % 1024, m_y, l, src, "R5");
            if (m_off + l < m_w) m_off += l;
            else begin
               m_off = 0; m_y = (m_y + 1) % 512; m_h--;
            end
         end else if (p >= m_w) begin
            l = m_w;
            push_seg(m_x, m_y, l, src, (m_y == 511) ? "R6" : "R3");
            m_y = (m_y + 1) % 512; m_h--;
         end else begin
            l = p;
            push_seg(m_x, m_y, l, src, "R4");
            m_off = p;
         end
         src += l;
         p -= l;
      end
      cons_q.push_back(words - (p + 1) / 2);
      cons_tag_q.push_back(empty ? "R11" : "R7");
      burst_words = 16'(words);
      burst_vld   = 1'b1;
      @(negedge clk);
      burst_vld   = 1'b0;
      // R12 idle drops once a burst is taken
      chk(idle == 1'b0, "R12", longint'(idle), 0);
      while (cons_q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(exp_q.size() == 0, "R2 missing segments", exp_q.size(), 0);
      chk(idle == 1'b1, "R12 back to idle", longint'(idle), 1);
      chk(busy == (m_h != 0), "R8", longint'(busy), longint'(m_h != 0));
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk(idle == 1'b1 && busy == 1'b0 && line_vld == 1'b0 && done == 1'b0 && restart_warn == 1'b0,
          "R8 reset", {idle, busy, line_vld, done, restart_warn}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 empty rectangle after reset: no segments, nothing used
      do_burst(5);

      // R1 R3 R4 R5 R7: rows, leftover, resumption, overrun
      do_start(100, 10, 8, 4, 1'b0);
      do_burst(4);
      do_burst(3);
      do_burst(5);
      do_burst(10);

      // R6 row wrap and column wrap of resumed segment, read direction
      do_start(1020, 511, 6, 3, 1'b1);
      do_burst(2);
      do_burst(7);

      // R5 one row split across several bursts
      do_start(0, 200, 10, 2, 1'b0);
      do_burst(1);
      do_burst(1);
      do_burst(2);
      do_burst(3);
      // R9 restart while one row is still pending
      do_start(7, 3, 3, 1, 1'b1);
      do_burst(1);
      // R7 odd leftover when the rows run out
      do_burst(1);

      // R11 zero width with rows present
      do_start(5, 5, 0, 3, 1'b0);
      do_burst(4);
      // R9 restart while rows remain (zero-width rectangle keeps rows)
      do_start(50, 60, 4, 2, 1'b0);
      do_burst(4);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0 && cons_q.size() == 0, "R2 queues drained",
          exp_q.size() + cons_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule